// File: doc/BRIEF.md
# Packet-Driven Remote Memory Access Responder

This block answers memory requests sent by a remote processor as short byte packets. Bytes arrive on a stream that carries a start marker on the first beat and an end marker on the last beat. The block collects one packet, decodes its leading opcode byte, and then does one of the following:

- performs a single word read or write on a local memory port of 36-bit words,
- raises an interrupt strobe toward a separate status block, or
- discards the packet.

For every packet it accepts, it returns a response packet of zero to six bytes on an output byte stream.

Address and data fields are little-endian. A 24-bit word address sits in bytes 1 to 3. A 40-bit data field sits in bytes 4 to 8, which reaches the 36-bit word with four spare bits. An address the local memory does not hold gets an explicit error reply and never reaches the memory port. A packet that does not fit the protocol gets no reply. Instead it raises a link-error strobe, so the surrounding transport can drop the connection.

Only one packet is in flight at a time. The input stream stays blocked from the end of a packet until the response to that packet has left.

Top module: `remote_mem_responder`

## Requirements
- R1: A packet consists of the beats from one with `rx_first` set through one with `rx_last` set. A new `rx_first` beat discards any partial packet. A lone beat carrying `rx_first`, `rx_last` and `rx_empty` is a zero-length packet: it produces no response, no memory access and no link error.
- R2: Opcode 0x01 is a write. Bytes 1..3 give the word address, least significant byte first. Bytes 4..8 give a 40-bit value, least significant byte first, and its low `WORD_W` bits are written once to that address. The reply is the single byte 0x03.
- R3: Opcode 0x02 is a read of the word at the address in bytes 1..3. The reply has six bytes: 0x03, then the word zero-extended to 40 bits, sent least significant byte first. `tx_last` is set only on the sixth byte.
- R4: A read or write whose 24-bit address is equal to or greater than `MEM_WORDS` makes no memory request. The reply is the single byte 0x04. All 24 address bits take part in the compare, so no part of the address aliases.
- R5: A packet of more than 9 bytes is malformed. So is a packet whose opcode is not 0x01, 0x02, 0x03 or 0x06. A malformed packet gets no response and makes no memory access, and `link_err` is high for exactly one cycle. A 9-byte packet is still accepted.
- R6: Opcode 0x03 makes no memory access. Its reply is one beat with `tx_empty` and `tx_last` both set.
- R7: Opcode 0x06 pulses `irq_set` for one cycle, makes no memory access, and is answered with the single byte 0x03.
- R8: `mem_req` stays high from the start of an access until the cycle `mem_ready` is seen. Throughout that time `mem_addr`, `mem_we` and `mem_wdata` hold steady. `mem_rdata` is taken in the cycle `mem_ready` is high.
- R9: `rx_ready` is low from the acceptance of a packet's last beat until its response has completed. While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_empty` hold.
- R10: A read or write packet shorter than its full length treats the missing address and data bytes as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Request beat valid |
| rx_first | input | 1 | Beat opens a packet |
| rx_last | input | 1 | Beat closes a packet |
| rx_empty | input | 1 | Beat carries no byte (zero-length packet) |
| rx_data | input | 8 | Request byte |
| rx_ready | output | 1 | Responder can take a request beat |
| tx_valid | output | 1 | Response beat valid |
| tx_ready | input | 1 | Downstream takes the response beat |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Final beat of the response |
| tx_empty | output | 1 | Beat marks an empty response |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write word |
| mem_ready | input | 1 | Memory completes the access |
| mem_rdata | input | WORD_W | Read word, valid with mem_ready |
| link_err | output | 1 | One-cycle malformed-packet strobe |
| irq_set | output | 1 | One-cycle interrupt-set strobe |

## Verification
The bench builds the block with `MEM_WORDS` = 48 and `WORD_W` = 36. With 48 words, addresses 47 and 48 sit on either side of the range limit, so the boundary can be tested directly. Because 48 is not a power of two, the range compare cannot reduce to dropping high address bits. A 6-bit memory address also makes any aliasing of the upper address byte visible. A 36-bit word lets reads show the four zero pad bits in the fifth data byte, and lets writes show that the top nibble of the fifth data byte is dropped.

// File: rtl/rmr_pkg.sv
`timescale 1ns/1ps
package rmr_pkg;

    localparam int BYTE_W        = 8;
    localparam int MAX_REQ_BYTES = 9;
    localparam int REQ_LEN_W     = $clog2(MAX_REQ_BYTES + 2);
    localparam int ADDR_BYTES    = 3;
    localparam int DATA_BYTES    = 5;
    localparam int MAX_RSP_BYTES = 1 + DATA_BYTES;
    localparam int RSP_LEN_W     = $clog2(MAX_RSP_BYTES + 1);

    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_ACK   = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_FAIL  = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_IRQ   = 8'h06;

    typedef struct packed {
        logic [REQ_LEN_W-1:0]              len;
        logic [MAX_REQ_BYTES*BYTE_W-1:0]   bytes;
    } req_pkt_t;

    typedef struct packed {
        logic [RSP_LEN_W-1:0]              len;
        logic [MAX_RSP_BYTES*BYTE_W-1:0]   bytes;
    } rsp_pkt_t;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_MEM,
        EX_DRAIN
    } ex_state_e;

    function automatic logic [ADDR_BYTES*BYTE_W-1:0] req_addr(req_pkt_t p);
        return p.bytes[BYTE_W +: ADDR_BYTES*BYTE_W];
    endfunction

    function automatic logic [DATA_BYTES*BYTE_W-1:0] req_data(req_pkt_t p);
        return p.bytes[(1+ADDR_BYTES)*BYTE_W +: DATA_BYTES*BYTE_W];
    endfunction

    function automatic logic known_op(logic [BYTE_W-1:0] op);
        return (op == OPC_WRITE) || (op == OPC_READ) ||
               (op == OPC_ACK)   || (op == OPC_IRQ);
    endfunction

    function automatic rsp_pkt_t rsp_one(logic [BYTE_W-1:0] code);
        rsp_pkt_t r;
        r.len   = RSP_LEN_W'(1);
        r.bytes = {{(MAX_RSP_BYTES-1)*BYTE_W{1'b0}}, code};
        return r;
    endfunction

endpackage

// File: rtl/rmr_rx_collect.sv
`timescale 1ns/1ps
module rmr_rx_collect
    import rmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_first,
    input  logic        rx_last,
    input  logic        rx_empty,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        pkt_valid,
    output req_pkt_t    pkt,
    input  logic        pkt_done
);

    localparam logic [REQ_LEN_W-1:0] LEN_SAT = REQ_LEN_W'(MAX_REQ_BYTES + 1);

    logic                            have_q;
    req_pkt_t                        pkt_q;
    logic [REQ_LEN_W-1:0]            base_len;
    req_pkt_t                        pkt_nxt;
    logic                            take;

    assign rx_ready  = !have_q;
    assign pkt_valid = have_q;
    assign pkt       = pkt_q;
    assign take      = rx_valid && !have_q;

    always_comb begin
        base_len      = rx_first ? '0 : pkt_q.len;
        pkt_nxt.bytes = rx_first ? '0 : pkt_q.bytes;
        pkt_nxt.len   = base_len;
        if (!rx_empty) begin
            if (base_len < REQ_LEN_W'(MAX_REQ_BYTES))
                pkt_nxt.bytes[int'(base_len)*BYTE_W +: BYTE_W] = rx_data;
            if (base_len < LEN_SAT)
                pkt_nxt.len = base_len + REQ_LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            pkt_q  <= '0;
        end else begin
            if (pkt_done)
                have_q <= 1'b0;
            if (take) begin
                pkt_q <= pkt_nxt;
                if (rx_last)
                    have_q <= 1'b1;
            end
        end
    end

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid && !pkt_done |=> pkt_valid && $stable(pkt));

endmodule

// File: rtl/rmr_exec.sv
`timescale 1ns/1ps
module rmr_exec
    import rmr_pkg::*;
#(
    parameter int MEM_WORDS = 4096,
    parameter int WORD_W    = 36,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  req_pkt_t          pkt,
    output logic              pkt_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_load,
    output rsp_pkt_t          rsp,
    input  logic              tx_busy,
    output logic              link_err,
    output logic              irq_set
);

    localparam int FIELD_W = DATA_BYTES * BYTE_W;

    ex_state_e            state_q, state_nxt;
    logic [7:0]           op;
    logic [23:0]          addr24;
    logic [FIELD_W-1:0]   field;
    logic                 in_range;
    logic                 too_long;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_W-1:0]    wdata_q;
    logic                 we_q;
    logic [FIELD_W-1:0]   rd_field;

    assign op       = pkt.bytes[7:0];
    assign addr24   = req_addr(pkt);
    assign field    = req_data(pkt);
    assign in_range = {8'd0, addr24} < 32'(MEM_WORDS);
    assign too_long = pkt.len > REQ_LEN_W'(MAX_REQ_BYTES);
    assign rd_field = FIELD_W'(mem_rdata);

    assign mem_req   = (state_q == EX_MEM);
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    always_comb begin
        state_nxt = state_q;
        pkt_done  = 1'b0;
        rsp_load  = 1'b0;
        rsp       = '0;
        link_err  = 1'b0;
        irq_set   = 1'b0;
        unique case (state_q)
            EX_IDLE: begin
                if (pkt_valid) begin
                    if (pkt.len == '0) begin
                        pkt_done = 1'b1;
                    end else if (too_long || !known_op(op)) begin
                        link_err = 1'b1;
                        pkt_done = 1'b1;
                    end else if (op == OPC_ACK) begin
                        rsp_load  = 1'b1;
                        state_nxt = EX_DRAIN;
                    end else if (op == OPC_IRQ) begin
                        irq_set   = 1'b1;
                        rsp_load  = 1'b1;
                        rsp       = rsp_one(OPC_ACK);
                        state_nxt = EX_DRAIN;
                    end else if (!in_range) begin
                        rsp_load  = 1'b1;
                        rsp       = rsp_one(OPC_FAIL);
                        state_nxt = EX_DRAIN;
                    end else begin
                        state_nxt = EX_MEM;
                    end
                end
            end
            EX_MEM: begin
                if (mem_ready) begin
                    rsp_load  = 1'b1;
                    if (we_q) begin
                        rsp = rsp_one(OPC_ACK);
                    end else begin
                        rsp.len   = RSP_LEN_W'(MAX_RSP_BYTES);
                        rsp.bytes = {rd_field, OPC_ACK};
                    end
                    state_nxt = EX_DRAIN;
                end
            end
            EX_DRAIN: begin
                if (!tx_busy) begin
                    pkt_done  = 1'b1;
                    state_nxt = EX_IDLE;
                end
            end
            default: state_nxt = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EX_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_q == EX_IDLE && state_nxt == EX_MEM) begin
                addr_q  <= addr24[ADDR_W-1:0];
                wdata_q <= field[WORD_W-1:0];
                we_q    <= (op == OPC_WRITE);
            end
        end
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata));

    // R4
    mem_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> 32'(mem_addr) < 32'(MEM_WORDS));

endmodule

// File: rtl/rmr_tx.sv
`timescale 1ns/1ps
module rmr_tx
    import rmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rsp_load,
    input  rsp_pkt_t   rsp,
    output logic       busy,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_last,
    output logic       tx_empty
);

    logic                  busy_q;
    rsp_pkt_t              buf_q;
    logic [RSP_LEN_W-1:0]  idx_q;
    logic [7:0]            lane [MAX_RSP_BYTES];

    for (genvar g = 0; g < MAX_RSP_BYTES; g++) begin : g_lane
        assign lane[g] = buf_q.bytes[g*BYTE_W +: BYTE_W];
    end

    assign busy     = busy_q;
    assign tx_valid = busy_q;
    assign tx_empty = busy_q && (buf_q.len == '0);
    assign tx_last  = busy_q && ((buf_q.len == '0) ||
                                 (idx_q + RSP_LEN_W'(1) == buf_q.len));
    assign tx_data  = (busy_q && !tx_empty && idx_q < RSP_LEN_W'(MAX_RSP_BYTES))
                      ? lane[idx_q] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            buf_q  <= '0;
            idx_q  <= '0;
        end else if (rsp_load) begin
            busy_q <= 1'b1;
            buf_q  <= rsp;
            idx_q  <= '0;
        end else if (busy_q && tx_ready) begin
            if (tx_last)
                busy_q <= 1'b0;
            else
                idx_q <= idx_q + RSP_LEN_W'(1);
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) &&
                                  $stable(tx_last) && $stable(tx_empty));

    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_load |-> !busy_q);

endmodule

// File: rtl/remote_mem_responder.sv
`timescale 1ns/1ps
module remote_mem_responder
    import rmr_pkg::*;
#(
    parameter int MEM_WORDS = 4096,
    parameter int WORD_W    = 36,
    localparam int ADDR_W   = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_last,
    input  logic              rx_empty,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_empty,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              link_err,
    output logic              irq_set
);

    logic      pkt_valid;
    req_pkt_t  pkt;
    logic      pkt_done;
    logic      rsp_load;
    rsp_pkt_t  rsp;
    logic      tx_busy;

    rmr_rx_collect u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_first  (rx_first),
        .rx_last   (rx_last),
        .rx_empty  (rx_empty),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .pkt_valid (pkt_valid),
        .pkt       (pkt),
        .pkt_done  (pkt_done)
    );

    rmr_exec #(
        .MEM_WORDS (MEM_WORDS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_exec (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt       (pkt),
        .pkt_done  (pkt_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .rsp_load  (rsp_load),
        .rsp       (rsp),
        .tx_busy   (tx_busy),
        .link_err  (link_err),
        .irq_set   (irq_set)
    );

    rmr_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .rsp_load (rsp_load),
        .rsp      (rsp),
        .busy     (tx_busy),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_empty (tx_empty)
    );

    // R5
    malformed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        link_err |=> !tx_valid && !mem_req);

    // R7
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> tx_valid && tx_data == OPC_ACK && tx_last && !tx_empty);

    // R9
    tx_rx_block_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

endmodule

// File: tb/tb_remote_mem_responder.sv
`timescale 1ns/1ps
module tb_remote_mem_responder;

    localparam int MEM_WORDS = 48;
    localparam int WORD_W    = 36;
    localparam int ADDR_W    = $clog2(MEM_WORDS);
    localparam int NVEC      = 17;

    typedef struct packed {
        logic [3:0]  len;
        logic [79:0] req;
        logic [2:0]  rlen;
        logic [47:0] rsp;
        logic        empty;
        logic        err;
        logic        irq;
        logic        acc;
        logic        bp;
    } vec_t;

    // fields: len, request bytes (byte 0 rightmost), reply length, reply bytes,
    // empty reply, link error, irq strobe, memory access, backpressure
    localparam vec_t VECS [NVEC] = '{
        '{4'd9,  80'h00F54433221100000501, 3'd1, 48'h000000000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 write 5
        '{4'd4,  80'h00000000000000000502, 3'd6, 48'h054433221103, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 read 5
        '{4'd9,  80'h000EDDCCBBAA00002F01, 3'd1, 48'h000000000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 write 47
        '{4'd4,  80'h00000000000000002F02, 3'd6, 48'h0EDDCCBBAA03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 read 47
        '{4'd9,  80'h000EDDCCBBAA00003001, 3'd1, 48'h000000000004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 write 48
        '{4'd9,  80'h00099999999901000501, 3'd1, 48'h000000000004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 write 0x010005
        '{4'd4,  80'h00000000000000000502, 3'd6, 48'h054433221103, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 word 5 untouched
        '{4'd4,  80'h00000000000000003002, 3'd1, 48'h000000000004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 read 48
        '{4'd1,  80'h00000000000000000006, 3'd1, 48'h000000000003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 irq
        '{4'd1,  80'h00000000000000000003, 3'd0, 48'h000000000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 ack in
        '{4'd1,  80'h00000000000000000004, 3'd0, 48'h000000000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 op 4
        '{4'd1,  80'h00000000000000000005, 3'd0, 48'h000000000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 op 5
        '{4'd10, 80'hFFEEDDCCBBAA00000502, 3'd0, 48'h000000000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 ten bytes
        '{4'd9,  80'h00776655443300002F02, 3'd6, 48'h0EDDCCBBAA03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 nine bytes ok
        '{4'd2,  80'h00000000000000000601, 3'd1, 48'h000000000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 short write
        '{4'd2,  80'h00000000000000000602, 3'd6, 48'h000000000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 short read
        '{4'd1,  80'h00000000000000000002, 3'd6, 48'h0F0000000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}  // R10 R3 read 0
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic              rx_first = 1'b0;
    logic              rx_last  = 1'b0;
    logic              rx_empty = 1'b0;
    logic [7:0]        rx_data  = 8'h00;
    logic              rx_ready;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [7:0]        tx_data;
    logic              tx_last;
    logic              tx_empty;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic              mem_ready = 1'b0;
    logic [WORD_W-1:0] mem_rdata;
    logic              link_err;
    logic              irq_set;

    int checks = 0;
    int fails  = 0;
    int err_n  = 0;
    int irq_n  = 0;
    int acc_n  = 0;
    int lat    = 0;

    logic [WORD_W-1:0] mem [MEM_WORDS];

    always #2 clk = ~clk;

    remote_mem_responder #(.MEM_WORDS(MEM_WORDS), .WORD_W(WORD_W)) dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last),
        .rx_empty(rx_empty), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_empty(tx_empty),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .link_err(link_err), .irq_set(irq_set)
    );

    assign mem_rdata = mem[mem_addr];

    initial begin
        for (int i = 0; i < MEM_WORDS; i++)
            mem[i] = 36'hF00000000 | WORD_W'(i);
    end

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            lat       <= 0;
        end else if (mem_req && !mem_ready) begin
            if (lat == 1) begin
                mem_ready <= 1'b1;
                lat       <= 0;
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
        if (!rst && mem_req && mem_ready && mem_we)
            mem[mem_addr] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (link_err) err_n++;
            if (irq_set) irq_n++;
            if (mem_req && mem_ready) acc_n++;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_beat(input logic first, input logic last, input logic empty, input logic [7:0] d);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_first = first;
        rx_last  = last;
        rx_empty = empty;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_first = 1'b0;
        rx_last  = 1'b0;
        rx_empty = 1'b0;
    endtask

    task automatic send_pkt(input logic [3:0] len, input logic [79:0] req);
        if (len == 4'd0) begin
            put_beat(1'b1, 1'b1, 1'b1, 8'h00);
        end else begin
            for (int i = 0; i < int'(len); i++)
                put_beat(i == 0, i == int'(len) - 1, 1'b0, req[8*i +: 8]);
        end
    endtask

    task automatic collect(input logic bp, output int n, output logic [47:0] b,
                           output logic empty_seen, output logic rx_bad);
        logic got_last;
        n = 0;
        b = '0;
        empty_seen = 1'b0;
        rx_bad = 1'b0;
        got_last = 1'b0;
        for (int c = 0; c < 40 && !got_last; c++) begin
            @(negedge clk);
            tx_ready = bp ? ~tx_ready : 1'b1;
            if (tx_valid && tx_ready) begin
                if (rx_ready) rx_bad = 1'b1;
                if (tx_empty) empty_seen = 1'b1;
                else if (n < 6) begin
                    b[8*n +: 8] = tx_data;
                    n++;
                end
                if (tx_last) got_last = 1'b1;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [47:0] b;
        logic empty_seen, rx_bad;
        int e0, i0, a0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R9
        chk(rx_ready && !tx_valid && !mem_req && !link_err && !irq_set,
            "R9 reset state", {59'd0, rx_ready, tx_valid, mem_req, link_err, irq_set}, 64'h10);

        for (int v = 0; v < NVEC; v++) begin
            e0 = err_n; i0 = irq_n; a0 = acc_n;
            send_pkt(VECS[v].len, VECS[v].req);
            collect(VECS[v].bp, n, b, empty_seen, rx_bad);
            // R2 R3 R4 R6 R10 reply contents
            chk(n == int'(VECS[v].rlen) && b == VECS[v].rsp && empty_seen == VECS[v].empty,
                $sformatf("R2/R3/R4/R6/R10 reply vec %0d", v),
                {13'd0, empty_seen, 2'd0, n[1:0], b}, {13'd0, VECS[v].empty, 2'd0, VECS[v].rlen[1:0], VECS[v].rsp});
            // R5 link error strobe
            chk((err_n - e0) == int'(VECS[v].err), $sformatf("R5 link_err vec %0d", v),
                64'(err_n - e0), 64'(VECS[v].err));
            // R7 interrupt strobe
            chk((irq_n - i0) == int'(VECS[v].irq), $sformatf("R7 irq_set vec %0d", v),
                64'(irq_n - i0), 64'(VECS[v].irq));
            // R4 R8 memory accesses
            chk((acc_n - a0) == int'(VECS[v].acc), $sformatf("R4/R8 access count vec %0d", v),
                64'(acc_n - a0), 64'(VECS[v].acc));
            // R9 input blocked during reply
            chk(!rx_bad, $sformatf("R9 rx_ready during reply vec %0d", v), 64'(rx_bad), 64'd0);
        end

        // R1 zero-length packet: nothing happens
        e0 = err_n; i0 = irq_n; a0 = acc_n;
        send_pkt(4'd0, 80'd0);
        collect(1'b0, n, b, empty_seen, rx_bad);
        chk(n == 0 && !empty_seen && err_n == e0 && acc_n == a0 && irq_n == i0,
            "R1 zero-length ignored", 64'(n + 2*int'(empty_seen) + 4*(err_n - e0) + 8*(acc_n - a0)), 64'd0);
        chk(rx_ready, "R1 ready after zero-length", 64'(rx_ready), 64'd1);

        // R1 start marker discards a partial packet
        a0 = acc_n;
        put_beat(1'b1, 1'b0, 1'b0, 8'h01);
        put_beat(1'b0, 1'b0, 1'b0, 8'h07);
        put_beat(1'b1, 1'b0, 1'b0, 8'h02);
        put_beat(1'b0, 1'b0, 1'b0, 8'h05);
        put_beat(1'b0, 1'b0, 1'b0, 8'h00);
        put_beat(1'b0, 1'b1, 1'b0, 8'h00);
        collect(1'b1, n, b, empty_seen, rx_bad);
        chk(n == 6 && b == 48'h054433221103, "R1 restart on start marker", {16'd0, b}, 64'h054433221103);
        chk(acc_n - a0 == 1, "R1 single access after restart", 64'(acc_n - a0), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule